// File: doc/BRIEF.md
# Swap-Cell Electrode Pulse Sequencer

This block produces the digital on/off levels that drive the electrodes of a single qubit swap cell. The cell has four shuttling electrodes and one interaction electrode. A single start pulse launches one full swap, which runs in three parts. First, a forward shuttling cascade brings the two electrons next to each other. Second, a counted train of interaction pulses performs the spin exchange. Third, a reverse shuttling cascade moves the electrons apart again. At the end the block raises a one-cycle completion flag.

All timing comes from nested counters and decode logic. A cascade timer walks through a fixed table of shuttling steps. An inner counter shapes each interaction subsequence: a short off interval followed by a long on interval. An outer counter with reset and enable counts completed subsequences. The block has no external way to change the sequence. Its behaviour is set entirely by parameters.

Top module: `swap_pulse_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after `rst` is sampled high, `s_gate`, `a_gate` and `done` are all low, and the block returns to idle with both train counters at zero.
- R2: A `start` sampled high in idle begins the forward cascade on the next cycle. `s_gate` is then 4'b0001 (S1 on bit 0), 4'b0010 (S2 on bit 1) and 4'b0100 (S3 on bit 2), each for STEP_LEN cycles (default 4), in that order.
- R3: Each interaction subsequence lasts SUB_LEN = 256 cycles. `a_gate` is low for the first A_OFF = 2 cycles and high for the remaining 254.
- R4: Exactly REPS = 24 subsequences run back to back, and the first one starts on the cycle right after the forward cascade ends.
- R5: Right after the last subsequence, the reverse cascade drives `s_gate` to 4'b0100, 4'b0010, 4'b0001 and then 4'b0010, each for STEP_LEN cycles. `s_gate[3]` (S4) stays low at all times.
- R6: `done` is high for exactly one cycle, on the cycle right after the reverse cascade. On the next cycle the block is idle and will accept a new `start`.
- R7: A `start` that arrives while a swap is in progress has no effect. This includes a start during the done cycle. The output sequence continues unchanged.
- R8: In no cycle is `a_gate` high together with any `s_gate` bit, and at most one `s_gate` bit is high in any cycle.
- R9: Asserting `rst` in the middle of a swap aborts it. A later `start` then runs a complete, unshortened swap from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch one swap when sampled high in idle |
| s_gate | output | 4 | Shuttling electrode levels, bit 0 = S1 to bit 3 = S4 |
| a_gate | output | 1 | Interaction electrode level |
| done | output | 1 | One-cycle pulse when a swap finishes |

## Verification
The hardest points to reach from the ports are the boundaries between phases. These are the edge between one subsequence and the next, the last subsequence followed by the handover to the reverse cascade, and a done cycle followed at once by a new start. The bench expands each launched swap into a cycle-exact list of expected output vectors. It then compares every cycle, measures each high run on `a_gate`, and counts the rising edges between a start and its done. To reach the in-progress corner cases, the stimulus issues stray starts during the forward cascade, in the middle of the train and on the done cycle itself. It also launches a second swap on the first idle cycle after done, and it asserts reset partway through the train.

// File: rtl/swap_pulse_pkg.sv
package swap_pulse_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FWD   = 3'd1,
    PH_TRAIN = 3'd2,
    PH_REV   = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

  localparam int FWD_STEPS = 3;
  localparam int ALL_STEPS = 7;
  localparam int STEP_IW   = 3;

  // Decode of a cascade step index into the one-hot shuttle pattern.
  function automatic logic [3:0] step_gate(input logic [STEP_IW-1:0] idx);
    logic [3:0] g;
    case (idx)
      3'd0:    g = 4'b0001;
      3'd1:    g = 4'b0010;
      3'd2:    g = 4'b0100;
      3'd3:    g = 4'b0100;
      3'd4:    g = 4'b0010;
      3'd5:    g = 4'b0001;
      3'd6:    g = 4'b0010;
      default: g = 4'b0000;
    endcase
    return g;
  endfunction

  // Interaction level at a position inside one subsequence.
  function automatic logic a_level(input int unsigned pos, input int unsigned off_len);
    return pos >= off_len;
  endfunction

endpackage

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int STEP_LEN = 4,
  parameter int STEP_IW  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  output logic [STEP_IW-1:0] step,
  output logic               step_end
);
  localparam int CW = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_LEN - 1);

  logic [CW-1:0] dwell;

  assign step_end = run && (dwell == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      dwell <= '0;
      step  <= '0;
    end else if (run) begin
      if (dwell == LAST) begin
        dwell <= '0;
        step  <= step + 1'b1;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pulse_train.sv
module pulse_train
  import swap_pulse_pkg::*;
#(
  parameter int SUB_LEN = 256,
  parameter int A_OFF   = 2,
  parameter int REPS    = 24,
  parameter int IW      = $clog2(SUB_LEN),
  parameter int RW      = $clog2(REPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          a_lvl,
  output logic          sub_wrap,
  output logic          train_end,
  output logic [RW-1:0] rep_cnt
);
  localparam logic [IW-1:0] SUB_LAST = IW'(SUB_LEN - 1);
  localparam logic [RW-1:0] REP_LAST = RW'(REPS - 1);

  logic [IW-1:0] pos;

  assign sub_wrap  = run && (pos == SUB_LAST);
  assign train_end = sub_wrap && (rep_cnt == REP_LAST);
  assign a_lvl     = run && a_level(int'(pos), A_OFF);

  // Inner counter: synchronous reset whenever the train is not running.
  always_ff @(posedge clk) begin
    if (rst || !run) pos <= '0;
    else             pos <= (pos == SUB_LAST) ? '0 : pos + 1'b1;
  end

  // Outer counter: reset plus enable from the inner wrap.
  always_ff @(posedge clk) begin
    if (rst || !run || train_end) rep_cnt <= '0;
    else if (sub_wrap)            rep_cnt <= rep_cnt + 1'b1;
  end
endmodule

// File: rtl/swap_pulse_ctrl.sv
module swap_pulse_ctrl
  import swap_pulse_pkg::*;
#(
  parameter int STEP_LEN = 4,
  parameter int SUB_LEN  = 256,
  parameter int A_OFF    = 2,
  parameter int REPS     = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic [3:0] s_gate,
  output logic       a_gate,
  output logic       done
);
  localparam int IW = $clog2(SUB_LEN);
  localparam int RW = $clog2(REPS + 1);
  localparam logic [STEP_IW-1:0] FWD_LAST = STEP_IW'(FWD_STEPS - 1);
  localparam logic [STEP_IW-1:0] REV_LAST = STEP_IW'(ALL_STEPS - 1);

  phase_t phase;
  logic [STEP_IW-1:0] step;
  logic step_end;
  logic casc_run, train_run;
  logic a_lvl;
  // Internal events brought out for the checker.
  logic sub_wrap, train_end;
  logic [RW-1:0] rep_cnt;
  logic fwd_end, rev_end;

  assign casc_run  = (phase == PH_FWD) || (phase == PH_REV);
  assign train_run = (phase == PH_TRAIN);
  assign fwd_end   = (phase == PH_FWD) && step_end && (step == FWD_LAST);
  assign rev_end   = (phase == PH_REV) && step_end && (step == REV_LAST);

  cascade_timer #(.STEP_LEN(STEP_LEN), .STEP_IW(STEP_IW)) u_casc (
    .clk      (clk),
    .rst      (rst),
    .clear    (phase == PH_IDLE),
    .run      (casc_run),
    .step     (step),
    .step_end (step_end)
  );

  pulse_train #(.SUB_LEN(SUB_LEN), .A_OFF(A_OFF), .REPS(REPS), .IW(IW), .RW(RW)) u_train (
    .clk       (clk),
    .rst       (rst),
    .run       (train_run),
    .a_lvl     (a_lvl),
    .sub_wrap  (sub_wrap),
    .train_end (train_end),
    .rep_cnt   (rep_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:  if (start)     phase <= PH_FWD;
        PH_FWD:   if (fwd_end)   phase <= PH_TRAIN;
        PH_TRAIN: if (train_end) phase <= PH_REV;
        PH_REV:   if (rev_end)   phase <= PH_DONE;
        PH_DONE:                 phase <= PH_IDLE;
        default:                 phase <= PH_IDLE;
      endcase
    end
  end

  assign s_gate = casc_run ? step_gate(step) : 4'b0000;
  assign a_gate = a_lvl;
  assign done   = (phase == PH_DONE);
endmodule

// File: rtl/swap_pulse_chk.sv
module swap_pulse_chk #(
  parameter int REPS = 24,
  parameter int RW   = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    s_gate,
  input logic          a_gate,
  input logic          done,
  input logic          sub_wrap,
  input logic          train_end,
  input logic [RW-1:0] rep_cnt
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (s_gate == 4'b0 && !a_gate && !done)); // R1
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (rst) (sub_wrap && !train_end) |=> !a_gate); // R3
  AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst) rep_cnt < RW'(REPS)); // R4
  AST_REV_HANDOVER: assert property (@(posedge clk) disable iff (rst) train_end |=> (s_gate == 4'b0100)); // R5
  AST_S4_LOW: assert property (@(posedge clk) disable iff (rst) !s_gate[3]); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_AFTER_REV: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(s_gate == 4'b0010)); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(a_gate && (s_gate != 4'b0))); // R8
  AST_ONE_SHUTTLE: assert property (@(posedge clk) disable iff (rst) $onehot0(s_gate)); // R8
endmodule

bind swap_pulse_ctrl swap_pulse_chk #(.REPS(REPS), .RW(RW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .s_gate    (s_gate),
  .a_gate    (a_gate),
  .done      (done),
  .sub_wrap  (sub_wrap),
  .train_end (train_end),
  .rep_cnt   (rep_cnt)
);

// File: tb/swap_pulse_ctrl_test.sv
`timescale 1ns/1ps
module swap_pulse_ctrl_test;
  localparam int STEP_LEN = 4;
  localparam int SUB_LEN  = 256;
  localparam int A_OFF    = 2;
  localparam int REPS     = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] s_gate;
  logic a_gate, done;

  int checks = 0;
  int fails  = 0;

  // Expected vector: {done, a_gate, s_gate}
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  swap_pulse_ctrl #(.STEP_LEN(STEP_LEN), .SUB_LEN(SUB_LEN), .A_OFF(A_OFF), .REPS(REPS)) uut (
    .clk(clk), .rst(rst), .start(start), .s_gate(s_gate), .a_gate(a_gate), .done(done)
  );

  function automatic void push_n(input logic [5:0] v, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endfunction

  // Driver: launch a swap and record the expected sequence.
  task automatic launch(input bit expect_run);
    @(negedge clk); #1;
    start = 1'b1;
    if (expect_run) begin
      push_n(6'b000001, STEP_LEN, "R2");
      push_n(6'b000010, STEP_LEN, "R2");
      push_n(6'b000100, STEP_LEN, "R2");
      for (int r = 0; r < REPS; r++) begin
        push_n(6'b000000, A_OFF, "R3");
        push_n(6'b010000, SUB_LEN - A_OFF, "R4");
      end
      push_n(6'b000100, STEP_LEN, "R5");
      push_n(6'b000010, STEP_LEN, "R5");
      push_n(6'b000001, STEP_LEN, "R5");
      push_n(6'b000010, STEP_LEN, "R5");
      push_n(6'b100000, 1, "R6");
    end
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    #1;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every cycle against the scoreboard.
  logic a_prev = 1'b0;
  int   hi_len = 0;
  int   rises  = 0;
  always @(negedge clk) begin
    logic [5:0] exp_v;
    logic [5:0] act_v;
    string t;
    act_v = {done, a_gate, s_gate};
    if (exp_q.size() != 0) begin
      exp_v = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      exp_v = 6'b0;
      t = rst ? "R1" : "R7";
    end
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s at %0t: {done,a,s} actual %b expected %b", t, $time, act_v, exp_v);
    end
    checks++;
    if (a_gate && (s_gate != 4'b0)) begin
      fails++;
      $display("FAIL R8 overlap: a=%b s=%b expected no overlap", a_gate, s_gate);
    end
    if (rst) begin
      hi_len = 0; rises = 0; a_prev = 1'b0;
    end else begin
      if (a_gate && !a_prev) rises++;
      if (a_gate) hi_len++;
      if (!a_gate && a_prev) begin
        checks++;
        if (hi_len != SUB_LEN - A_OFF) begin
          fails++;
          $display("FAIL R3 high run actual %0d expected %0d", hi_len, SUB_LEN - A_OFF);
        end
        hi_len = 0;
      end
      if (done) begin
        checks++;
        if (rises != REPS) begin
          fails++;
          $display("FAIL R4 subsequence count actual %0d expected %0d", rises, REPS);
        end
        rises = 0;
      end
      a_prev = a_gate;
    end
  end

  initial begin
    // R1: reset state held for a few cycles
    wait_cycles(5);
    #1 rst = 1'b0;
    wait_cycles(3);
    // R2 R3 R4 R5 R6 with R7 stray starts during forward cascade and train
    launch(1'b1);
    wait_cycles(3);
    #1 start = 1'b1; @(negedge clk); #1 start = 1'b0;
    wait_cycles(1000);
    #1 start = 1'b1; @(negedge clk); #1 start = 1'b0;
    // R7: start on the done cycle is ignored
    while (exp_q.size() != 1) @(negedge clk);
    #1 start = 1'b1; @(negedge clk); #1 start = 1'b0;
    wait_cycles(4);
    // R6: back-to-back launch on the first idle cycle after done
    launch(1'b1);
    wait_drain();
    launch(1'b1);
    wait_drain();
    wait_cycles(3);
    // R9: reset partway through the train, then a full swap
    launch(1'b1);
    wait_cycles(2000);
    #1 rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    wait_cycles(3);
    #1 rst = 1'b0;
    wait_cycles(2);
    launch(1'b1);
    wait_drain();
    wait_cycles(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule